// File: doc/BRIEF.md
# Shared Buffer Descriptor Ring Manager

This block owns one table of buffer descriptors that both directions of a network controller share. Each descriptor is two 32-bit words: a control word with the frame length in the upper half and flag bits in the lower half, followed by a buffer-address word. A boundary count N splits the table: descriptors below N form the transmit ring and descriptors from N to the top form the receive ring. The host reads and writes the table through a byte-addressed window, and it uses a small register port to set N, the interrupt mask and the interrupt source bits, which it clears by writing ones.

On the transmit side the block watches the current descriptor. When it is ready and long enough, the block raises a start request that carries the buffer address, the length and the pad and CRC flags. The request holds until the data engine returns a done pulse. Then the block retires the descriptor and moves to the next one. On the receive side the block shows whether the current descriptor is free and where its buffer lives. A completion report carries a length and nine status bits, which the block writes back into the descriptor before it advances.

Top module: `desc_ring_mgr`

## Requirements
- R1: After reset, N reads as NRST, the mask and source registers read 0, irq is 0, tx_req is 0 and the transmit pointer is 0.
- R2: Descriptor word w (control word at 2i, buffer word at 2i+1) sits at byte address 4w, and byte address bits 1:0 are ignored. A write followed by a read of the same word returns the written value.
- R3: A transmit starts (tx_req rises one cycle later) only when tx_en is 1, N is not 0, bit 15 (ready) of the current control word is set and its length field (bits 31:16) is greater than 4.
- R4: tx_req stays high with tx_buf_ptr, tx_len, tx_pad (bit 12) and tx_crc (bit 11) unchanged until a cycle with tx_done high, and it is low in the cycle after that. A tx_done pulse while tx_req is low has no effect.
- R5: On transmit completion the pointer goes to 0 if bit 13 (wrap) of the descriptor was set. Otherwise it goes to the next index, and it goes to 0 when that index reaches N.
- R6: On transmit completion bit 15 and bits 8:0 of the control word are cleared, and the length and bits 14:9 are kept.
- R7: rx_ready is 1 only when rx_en is 1, N is less than NDESC and bit 15 (empty) of the current receive control word is set. rx_buf_ptr shows that descriptor's buffer word.
- R8: A cycle with rx_done and rx_ready both high writes {rx_len, 0, old bits 14:9, rx_stat} into the current control word. rx_done while rx_ready is low changes nothing.
- R9: After a receive completion the receive pointer goes to N if bit 13 (wrap) was set or the pointer was NDESC-1. Otherwise it goes to the next index.
- R10: A 0-to-1 change of rx_en sets the receive pointer to N. A 0-to-1 change of tx_en sets the transmit pointer to 0.
- R11: A completing descriptor with bit 14 set raises source bit 0 (transmit) or source bit 2 (receive). Writing the source register clears the bits written as 1, and a set in the same cycle wins. irq is the OR of source AND mask.
- R12: Register port addresses: 0 is the interrupt source, 1 is the interrupt mask (bits 2:0), 2 is N. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dsc_wr | input | 1 | Descriptor window write strobe |
| dsc_addr | input | AW | Descriptor window byte address |
| dsc_wdata | input | 32 | Descriptor write data |
| dsc_rdata | output | 32 | Descriptor read data (combinational) |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_req | output | 1 | Transmit start request |
| tx_buf_ptr | output | 32 | Buffer address of the frame to send |
| tx_len | output | 16 | Length of the frame to send |
| tx_pad | output | 1 | Pad flag of the frame to send |
| tx_crc | output | 1 | CRC flag of the frame to send |
| tx_done | input | 1 | Transmit completion pulse |
| rx_ready | output | 1 | Current receive descriptor may take a frame |
| rx_buf_ptr | output | 32 | Buffer address of the current receive descriptor |
| rx_done | input | 1 | Receive completion pulse |
| rx_len | input | 16 | Received length to record |
| rx_stat | input | 9 | Receive status bits to record |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle the assertions check the transmit handshake: the request holds with steady address and length until done and then drops, a request never rises without transmit enabled, rx_ready never shows while receive is off, and irq only rises after a completion or a register write. Pointer movement, the wrap and boundary rules, the write-back of control words and the write-one-to-clear behaviour need known descriptor contents. Only the bench's scenarios can show these, by sweeping N over every value of a small table and following the buffer addresses the block reports.

// File: rtl/desc_ring_mgr.sv
module desc_ring_mgr #(
  parameter int NDESC = 128,
  parameter int NRST  = NDESC / 2,
  localparam int IW   = $clog2(NDESC),
  localparam int AW   = IW + 3,
  localparam int NW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dsc_wr,
  input  logic [AW-1:0] dsc_addr,
  input  logic [31:0]   dsc_wdata,
  output logic [31:0]   dsc_rdata,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          tx_en,
  input  logic          rx_en,
  output logic          tx_req,
  output logic [31:0]   tx_buf_ptr,
  output logic [15:0]   tx_len,
  output logic          tx_pad,
  output logic          tx_crc,
  input  logic          tx_done,
  output logic          rx_ready,
  output logic [31:0]   rx_buf_ptr,
  input  logic          rx_done,
  input  logic [15:0]   rx_len,
  input  logic [8:0]    rx_stat,
  output logic          irq
);
  localparam logic [NW-1:0] NFULL = NW'(NDESC);
  localparam logic [IW-1:0] LAST  = IW'(NDESC - 1);

  logic [31:0]   mem [2*NDESC];
  logic [NW-1:0] bnd;
  logic [IW-1:0] tx_ptr, tx_idx, rx_ptr;
  logic          tx_busy, tx_wrp, tx_irq;
  logic          tx_en_q, rx_en_q;
  logic [2:0]    src, msk;

  wire [IW:0]   dwa    = dsc_addr[AW-1:2];
  wire [31:0]   tx_cur = mem[{tx_ptr, 1'b0}];
  wire [31:0]   rx_cur = mem[{rx_ptr, 1'b0}];
  wire          tx_rise = tx_en & ~tx_en_q;
  wire          rx_rise = rx_en & ~rx_en_q;
  wire          tx_go  = tx_en && !tx_rise && !tx_busy && bnd != '0 &&
                         tx_cur[15] && tx_cur[31:16] > 16'd4;
  wire          tx_fin = tx_busy && tx_done;
  wire          rx_fin = rx_ready && rx_done;
  wire [NW-1:0] tx_inc = NW'(tx_idx) + 1'b1;
  wire [IW-1:0] tx_nxt = (tx_wrp || tx_inc >= bnd) ? '0 : tx_idx + 1'b1;
  wire [IW-1:0] rx_nxt = (rx_cur[13] || rx_ptr == LAST) ? bnd[IW-1:0] : rx_ptr + 1'b1;
  wire [2:0]    clr    = (reg_wr && reg_addr == 2'd0) ? reg_wdata[2:0] : 3'b000;

  assign dsc_rdata  = mem[dwa];
  assign rx_ready   = rx_en && rx_en_q && bnd < NFULL && rx_cur[15];
  assign rx_buf_ptr = mem[{rx_ptr, 1'b1}];
  assign tx_req     = tx_busy;
  assign irq        = |(src & msk);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {5'd0, src};
      2'd1:    reg_rdata = {5'd0, msk};
      2'd2:    reg_rdata = 8'(bnd);
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NDESC; i++) mem[i] <= '0;
    end else begin
      if (dsc_wr) mem[dwa] <= dsc_wdata;
      if (tx_fin) mem[{tx_idx, 1'b0}] <= mem[{tx_idx, 1'b0}] & ~32'h0000_81FF;
      if (rx_fin) mem[{rx_ptr, 1'b0}] <= {rx_len, 1'b0, rx_cur[14:9], rx_stat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd <= NW'(NRST);
      msk <= '0;
      src <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd1) msk <= reg_wdata[2:0];
      if (reg_wr && reg_addr == 2'd2) bnd <= NW'(reg_wdata);
      src <= (src & ~clr) | {rx_fin && rx_cur[14], 1'b0, tx_fin && tx_irq};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ptr     <= '0;
      tx_idx     <= '0;
      tx_busy    <= 1'b0;
      tx_wrp     <= 1'b0;
      tx_irq     <= 1'b0;
      tx_buf_ptr <= '0;
      tx_len     <= '0;
      tx_pad     <= 1'b0;
      tx_crc     <= 1'b0;
      tx_en_q    <= 1'b0;
    end else begin
      tx_en_q <= tx_en;
      if (tx_go) begin
        tx_busy    <= 1'b1;
        tx_idx     <= tx_ptr;
        tx_wrp     <= tx_cur[13];
        tx_irq     <= tx_cur[14];
        tx_pad     <= tx_cur[12];
        tx_crc     <= tx_cur[11];
        tx_len     <= tx_cur[31:16];
        tx_buf_ptr <= mem[{tx_ptr, 1'b1}];
      end
      if (tx_fin) begin
        tx_busy <= 1'b0;
        tx_ptr  <= tx_nxt;
      end
      if (tx_rise) tx_ptr <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ptr  <= IW'(NRST);
      rx_en_q <= 1'b0;
    end else begin
      rx_en_q <= rx_en;
      if (rx_fin)  rx_ptr <= rx_nxt;
      if (rx_rise) rx_ptr <= bnd[IW-1:0];
    end
  end
endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_en,
  input logic        rx_en,
  input logic        tx_req,
  input logic        tx_done,
  input logic [31:0] tx_buf_ptr,
  input logic [15:0] tx_len,
  input logic        rx_ready,
  input logic        rx_done,
  input logic        reg_wr,
  input logic        irq
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req);
  assert_req_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> $stable(tx_buf_ptr) && $stable(tx_len));
  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req);
  assert_start_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(tx_en));
  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_en);
  assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_done || rx_done || reg_wr));
endmodule

bind desc_ring_mgr desc_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
  .tx_req(tx_req), .tx_done(tx_done), .tx_buf_ptr(tx_buf_ptr),
  .tx_len(tx_len), .rx_ready(rx_ready), .rx_done(rx_done),
  .reg_wr(reg_wr), .irq(irq)
);

// File: tb/tb_desc_ring_mgr.sv
module tb_desc_ring_mgr;
  localparam int ND = 8;
  localparam int NR = 4;
  localparam int AW = $clog2(ND) + 3;

  logic clk = 0, rst_n = 0;
  logic dsc_wr = 0, reg_wr = 0, tx_en = 0, rx_en = 0, tx_done = 0, rx_done = 0;
  logic [AW-1:0] dsc_addr = '0;
  logic [31:0] dsc_wdata = '0, dsc_rdata, tx_buf_ptr, rx_buf_ptr;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [15:0] tx_len, rx_len = '0;
  logic [8:0] rx_stat = '0;
  logic tx_req, tx_pad, tx_crc, rx_ready, irq;
  int total = 0, bad = 0;
  bit fin = 0;

  always #10 clk = ~clk;

  desc_ring_mgr #(.NDESC(ND), .NRST(NR)) dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic dw(int w, logic [31:0] d);
    dsc_addr = AW'(w * 4); dsc_wdata = d; dsc_wr = 1; tick(); dsc_wr = 0;
  endtask

  function automatic logic [31:0] dr(int w);
    return dsc_rdata;
  endfunction

  task automatic rd(int w, output logic [31:0] v);
    dsc_addr = AW'(w * 4); #1; v = dsc_rdata;
  endtask

  task automatic rw(int a, int d);
    reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rr(int a, output logic [7:0] v);
    reg_addr = 2'(a); #1; v = reg_rdata;
  endtask

  task automatic txd(); tx_done = 1; tick(); tx_done = 0; endtask

  task automatic rxd(int l, int s);
    rx_len = 16'(l); rx_stat = 9'(s); rx_done = 1; tick(); rx_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state, R12 map
    rr(0, b); chk("R1 src", 32'(b), 0);
    rr(1, b); chk("R1 mask", 32'(b), 0);
    rr(2, b); chk("R12 N", 32'(b), NR);
    rr(3, b); chk("R12 spare", 32'(b), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_req", 32'(tx_req), 0);

    // R2 window sweep with ignored low address bits
    for (int w = 0; w < 2*ND; w++) begin
      dsc_addr = AW'(w * 4 + (w % 4)); dsc_wdata = 32'(w) * 32'h0123_4567 ^ 32'h5A5A_0000;
      dsc_wr = 1; tick(); dsc_wr = 0;
    end
    for (int w = 0; w < 2*ND; w++) begin
      rd(w, v); chk("R2 readback", v, 32'(w) * 32'h0123_4567 ^ 32'h5A5A_0000);
    end

    // R4 stray done, R3 length gate, R5 wrap bit
    for (int i = 0; i < 2*ND; i++) dw(i, (i % 2) ? 32'h100 + 32'(i/2) : 0);
    rw(2, 4); tx_en = 1; tick(); tick();
    txd(); tick();
    dw(0, {16'd4, 16'h8000}); tick(); tick();
    chk("R3 len4 no start", 32'(tx_req), 0);
    dw(2, {16'd5, 16'hA000});
    dw(0, {16'd5, 16'h9800}); tick();
    chk("R3 start", 32'(tx_req), 1);
    chk("R4 stray done ignored", tx_buf_ptr, 32'h100);
    chk("R4 len", 32'(tx_len), 5);
    chk("R4 pad", 32'(tx_pad), 1);
    chk("R4 crc", 32'(tx_crc), 1);
    repeat (3) tick();
    chk("R4 hold", tx_buf_ptr, 32'h100);
    txd();
    chk("R4 drop", 32'(tx_req), 0);
    tick();
    chk("R5 next", tx_buf_ptr, 32'h101);
    txd(); tick(); tick();
    chk("R5 wrap bit", 32'(tx_req), 0);
    dw(0, {16'd6, 16'h8000}); tick();
    chk("R5 wrap to 0", tx_buf_ptr, 32'h100);
    txd(); tick();
    // R3 N=0 and tx disabled
    tx_en = 0; rw(2, 0); dw(0, {16'd8, 16'h8000}); tx_en = 1; tick(); tick(); tick();
    chk("R3 N zero", 32'(tx_req), 0);
    tx_en = 0; rw(2, 4); tick(); tick();
    chk("R3 disabled", 32'(tx_req), 0);

    // R5/R6/R10 sweep of N
    for (int n = 1; n <= ND; n++) begin
      tx_en = 0; tick();
      for (int i = 0; i < ND; i++) begin
        dw(2*i+1, 32'h100 + 32'(i)); dw(2*i, {16'd8, 16'h91FF});
      end
      rw(2, n); tx_en = 1; tick(); tick();
      for (int k = 0; k < n; k++) begin
        chk("R5 sweep req", 32'(tx_req), 1);
        chk("R5 sweep ptr", tx_buf_ptr, 32'h100 + 32'(k));
        txd(); tick();
      end
      chk("R5 sweep end", 32'(tx_req), 0);
      rd(0, v); chk("R6 cleared", v, {16'd8, 16'h1000});
      dw(0, {16'd8, 16'h8000}); tick();
      chk("R10 R5 return 0", tx_buf_ptr, 32'h100);
      txd(); tick();
    end
    tx_en = 0;

    // R7/R8/R9/R10 sweep of N on receive
    for (int n = 0; n < ND; n++) begin
      rx_en = 0; tick();
      for (int i = 0; i < ND; i++) begin
        dw(2*i+1, 32'h200 + 32'(i)); dw(2*i, 32'h0000_91FF);
      end
      rw(2, n); rx_en = 1; tick(); tick();
      chk("R10 rx ptr", rx_buf_ptr, 32'h200 + 32'(n));
      for (int k = 0; k < ND - n; k++) begin
        chk("R7 ready", 32'(rx_ready), 1);
        chk("R9 ptr", rx_buf_ptr, 32'h200 + 32'(n + k));
        rxd(k + 20, 9'h0A5 ^ k);
        rd(2*(n+k), v); chk("R8 word", v, {16'(k + 20), 16'h1000 | 16'(9'h0A5 ^ k)});
      end
      chk("R9 top back to N", rx_buf_ptr, 32'h200 + 32'(n));
      chk("R7 not empty", 32'(rx_ready), 0);
    end
    rx_en = 0; rw(2, ND); dw(2*(ND-1), 32'h8000); rx_en = 1; tick(); tick();
    chk("R7 N full", 32'(rx_ready), 0);
    rx_en = 0; rw(2, 4);
    dw(8, 32'h8000); dw(10, 32'hA000); dw(12, 32'h8000);
    rxd(3, 1); rd(8, v);
    chk("R8 ignored", v, 32'h8000);
    rx_en = 1; tick(); tick();
    rxd(7, 0); rxd(7, 0);
    chk("R9 wrap bit", rx_buf_ptr, 32'h204);

    // R11 interrupts
    rx_en = 0; rw(1, 5);
    dw(0, {16'd9, 16'hC000}); tx_en = 1; tick(); tick(); tick();
    txd();
    chk("R11 tx src irq", {30'd0, irq, 1'b0}, 2);
    rr(0, b); chk("R11 src bit0", 32'(b), 1);
    rw(0, 1); rr(0, b); chk("R11 w1c", 32'(b), 0);
    chk("R11 irq low", 32'(irq), 0);
    rw(2, 4); dw(8, 32'hC000); rx_en = 1; tick(); tick(); rxd(5, 0);
    rr(0, b); chk("R11 src bit2", 32'(b), 4);
    rw(1, 1); chk("R11 masked", 32'(irq), 0);
    rw(1, 4); chk("R11 unmasked", 32'(irq), 1);
    rw(0, 0); rr(0, b); chk("R11 zero write keeps", 32'(b), 4);
    rw(0, 4); chk("R11 cleared", 32'(irq), 0);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule